// File: doc/BRIEF.md
# Auto-Increment CPU Bus Port

This block lets an asynchronous 8-bit processor bus reach a byte-wide video memory held inside the block. The bus side gives an active-low chip-select, separate active-low read and write strobes, a 5-bit register address and an 8-bit write byte. These inputs are re-timed into the system clock before any decision is made. A small register file sets a memory pointer and a step code. A data port reads or writes memory at the pointer.

Every data-port access moves the pointer on by the programmed step, so software can stream through memory without reloading the address. Each side effect commits once, when the access ends. It uses the register address that was held while the access was active, so an address bus that moves at the same instant as the strobe release cannot redirect it.

The data-port read byte is fetched ahead of time from the pointer location. It is therefore valid as soon as a read starts, and two reads in quick succession return two successive bytes. Register map: offset 0 holds pointer bits 7:0, offset 1 holds the pointer bits above 7, offset 2 holds the step code in bits 3:0 (bits 7:4 read as zero), and offset 3 is the data port. All other offsets are unmapped.

Top module: `vbus_port`

## Requirements
- R1: After reset the pointer is 0 and the step code is 0, so offsets 0, 1 and 2 all read 0x00.
- R2: A write to offset 0 sets pointer bits 7:0. A write to offset 1 sets the pointer bits above 7 from the low bits of the byte. Both offsets read back the pointer, with unused high bits read as zero.
- R3: A write to offset 2 stores bits 3:0 as the step code, and offset 2 reads back {4'b0, code}. Code 0 means a step of 0. A code k from 1 to 9 means a step of 2^(k-1), which gives 1, 2, 4 and so on up to 256. Codes 10 to 15 mean a step of 0.
- R4: A read of offset 3 returns the memory byte at the pointer, and that byte is valid at the moment the read strobe asserts.
- R5: After every offset-3 access, read or write, the pointer advances by the step. It wraps modulo 2^AW.
- R6: A write to offset 3 stores the bus byte at the pointer address that was current before the advance.
- R7: Two offset-3 reads, with the next one starting four clocks after the previous one ends, return two successive memory bytes and never the same byte twice when the step is non-zero.
- R8: A side effect commits only when chip-select or the strobe deasserts. It uses the address held during the access, even if the address bus changes at the same moment as the release.
- R9: Offsets 4 to 31 read as 0x00, and writes to them change no register and no memory.
- R10: Reads of offsets 0, 1 and 2 leave the pointer and the step code unchanged.
- R11: With a step of 0, repeated offset-3 reads return the same byte and the pointer does not move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_cs_n | input | 1 | Bus chip-select, active low, asynchronous |
| bus_rd_n | input | 1 | Read strobe, active low, asynchronous |
| bus_wr_n | input | 1 | Write strobe, active low, asynchronous |
| bus_addr | input | 5 | Register offset |
| bus_wdata | input | 8 | Byte written by the processor |
| bus_rdata | output | 8 | Byte returned for the offset now on bus_addr |

## Verification
Two events can land in the same clock: the strobe release and a change of the address bus. Both reach the synchroniser outputs in the same sample. The bench ends every access by moving the address and releasing the strobes together. It then checks that the commit followed the held offset, for example a pointer write released onto the data-port offset must neither write memory nor step the pointer. A second overlap comes from back-to-back reads, where the pointer advance of one read meets the prefetch for the next. The bench judges this by reading the expected successive bytes right after the next strobe asserts.

// File: rtl/vbp_pkg.sv
package vbp_pkg;
    localparam int OFS_W = 5;
    typedef logic [OFS_W-1:0] ofs_t;

    localparam ofs_t OFS_PTR_LO = 5'd0;
    localparam ofs_t OFS_PTR_HI = 5'd1;
    localparam ofs_t OFS_STEP   = 5'd2;
    localparam ofs_t OFS_DATA   = 5'd3;

    localparam int STEP_CODE_W   = 4;
    localparam int STEP_CODE_MAX = 9;
endpackage

// File: rtl/vbp_sync.sv
module vbp_sync #(
    parameter int W = 1,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= {chain_q[STAGES-2:0], d};
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/vbp_step.sv
module vbp_step #(
    parameter int AW = 10
) (
    input  logic [vbp_pkg::STEP_CODE_W-1:0] code,
    output logic [AW-1:0]                   step
);
    for (genvar b = 0; b < AW; b++) begin : g_bit
        if (b < vbp_pkg::STEP_CODE_MAX) begin : g_live
            assign step[b] = (code == vbp_pkg::STEP_CODE_W'(b + 1));
        end else begin : g_zero
            assign step[b] = 1'b0;
        end
    end
endmodule

// File: rtl/vbp_vram.sv
module vbp_vram #(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    localparam int DEPTH = 1 << AW;
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        rdata <= mem[raddr];
    end
endmodule

// File: rtl/vbus_port.sv
module vbus_port #(
    parameter int AW = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_cs_n,
    input  logic       bus_rd_n,
    input  logic       bus_wr_n,
    input  logic [4:0] bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata
);
    import vbp_pkg::*;

    localparam int HI_W  = AW - 8;
    localparam int PAD_W = 8 - HI_W;

    typedef struct packed {
        logic [AW-1:0]          ptr;
        logic [STEP_CODE_W-1:0] step_code;
        ofs_t                   cap_addr;
        logic [7:0]             cap_wdata;
        logic                   cap_wr;
        logic                   act_prev;
    } state_t;

    state_t st_d, st_q;

    logic [2:0]  ctl_s;
    logic [12:0] dat_s;
    logic        cs_s, rd_s, wr_s;
    ofs_t        addr_s;
    logic [7:0]  wdata_s;
    logic        active_s;
    logic        acc_end;
    logic [AW-1:0] step_val;
    logic        mem_we;
    logic [7:0]  prefetch;

    vbp_sync #(.W(3), .STAGES(2), .RST_VAL(3'b111)) ctl_sync_i (
        .clk(clk), .rst_n(rst_n),
        .d({bus_cs_n, bus_rd_n, bus_wr_n}), .q(ctl_s)
    );

    vbp_sync #(.W(13), .STAGES(2), .RST_VAL(13'd0)) dat_sync_i (
        .clk(clk), .rst_n(rst_n),
        .d({bus_addr, bus_wdata}), .q(dat_s)
    );

    assign {cs_s, rd_s, wr_s} = ctl_s;
    assign {addr_s, wdata_s}  = dat_s;
    assign active_s = !cs_s && (!rd_s || !wr_s);
    assign acc_end  = st_q.act_prev && !active_s;

    vbp_step #(.AW(AW)) step_i (.code(st_q.step_code), .step(step_val));

    vbp_vram #(.AW(AW)) vram_i (
        .clk(clk), .we(mem_we), .waddr(st_q.ptr), .wdata(st_q.cap_wdata),
        .raddr(st_q.ptr), .rdata(prefetch)
    );

    always_comb begin
        st_d = st_q;
        mem_we = 1'b0;
        st_d.act_prev = active_s;
        if (active_s) begin
            st_d.cap_addr  = addr_s;
            st_d.cap_wdata = wdata_s;
            st_d.cap_wr    = !wr_s;
        end
        if (acc_end) begin
            case (st_q.cap_addr)
                OFS_PTR_LO: if (st_q.cap_wr) st_d.ptr[7:0] = st_q.cap_wdata;
                OFS_PTR_HI: if (st_q.cap_wr) st_d.ptr[AW-1:8] = st_q.cap_wdata[HI_W-1:0];
                OFS_STEP:   if (st_q.cap_wr) st_d.step_code = st_q.cap_wdata[STEP_CODE_W-1:0];
                OFS_DATA: begin
                    mem_we   = st_q.cap_wr;
                    st_d.ptr = st_q.ptr + step_val;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        case (bus_addr)
            OFS_PTR_LO: bus_rdata = st_q.ptr[7:0];
            OFS_PTR_HI: bus_rdata = {{PAD_W{1'b0}}, st_q.ptr[AW-1:8]};
            OFS_STEP:   bus_rdata = {{(8-STEP_CODE_W){1'b0}}, st_q.step_code};
            OFS_DATA:   bus_rdata = prefetch;
            default:    bus_rdata = 8'h00;
        endcase
    end

    logic [AW-1:0]          ptr_q;
    logic [STEP_CODE_W-1:0] step_code_q;
    ofs_t                   cap_addr_q;
    logic                   cap_wr_q;
    assign ptr_q       = st_q.ptr;
    assign step_code_q = st_q.step_code;
    assign cap_addr_q  = st_q.cap_addr;
    assign cap_wr_q    = st_q.cap_wr;
endmodule

// File: rtl/vbus_port_chk.sv
module vbus_port_chk #(
    parameter int AW = 10
) (
    input logic          clk,
    input logic          rst_n,
    input logic          acc_end,
    input logic [4:0]    cap_addr,
    input logic [AW-1:0] ptr_q,
    input logic [3:0]    step_code
);
    p_ptr_moves_at_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ptr_q) |-> $past(acc_end));

    p_held_addr_at_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
        acc_end |-> $stable(cap_addr));

    p_unmapped_inert_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_end && cap_addr > 5'd3) |=> ($stable(ptr_q) && $stable(step_code)));

    p_unit_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_end && cap_addr == 5'd3 && step_code == 4'd1) |=> (ptr_q == AW'($past(ptr_q) + AW'(1))));

    p_zero_step_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_end && cap_addr == 5'd3 && step_code == 4'd0) |=> $stable(ptr_q));
endmodule

bind vbus_port vbus_port_chk #(.AW(AW)) chk_i (
    .clk(clk), .rst_n(rst_n), .acc_end(acc_end), .cap_addr(cap_addr_q),
    .ptr_q(ptr_q), .step_code(step_code_q)
);

// File: tb/vbus_port_tb.sv
`timescale 1ns/1ps
module vbus_port_tb_top;
    localparam int AW = 10;
    localparam int DEPTH = 1 << AW;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_cs_n = 1'b1, bus_rd_n = 1'b1, bus_wr_n = 1'b1;
    logic [4:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;

    int n_vec = 0, n_bad = 0;
    bit done = 0;

    int  m_ptr = 0;
    int  m_code = 0;
    byte unsigned m_mem [DEPTH];

    always #2.5 clk = ~clk;

    vbus_port #(.AW(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_cs_n(bus_cs_n), .bus_rd_n(bus_rd_n),
        .bus_wr_n(bus_wr_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata)
    );

    function automatic int m_step();
        if (m_code >= 1 && m_code <= 9) return 1 << (m_code - 1);
        return 0;
    endfunction

    function automatic logic [7:0] exp_rd(input logic [4:0] a);
        case (a)
            5'd0: return 8'(m_ptr & 8'hFF);
            5'd1: return 8'(m_ptr >> 8);
            5'd2: return 8'(m_code);
            5'd3: return m_mem[m_ptr];
            default: return 8'h00;
        endcase
    endfunction

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic commit(input bit is_wr, input logic [4:0] a, input logic [7:0] d);
        case (a)
            5'd0: if (is_wr) m_ptr = (m_ptr & 32'h300) | int'(d);
            5'd1: if (is_wr) m_ptr = (m_ptr & 32'hFF) | (int'(d[1:0]) << 8);
            5'd2: if (is_wr) m_code = int'(d[3:0]);
            5'd3: begin
                if (is_wr) m_mem[m_ptr] = d;
                m_ptr = (m_ptr + m_step()) % DEPTH;
            end
            default: ;
        endcase
    endtask

    // Access ends with the address moving to rel_a on the same instant as the strobe release.
    task automatic access(input bit is_wr, input logic [4:0] a, input logic [7:0] d,
                          input logic [4:0] rel_a, input int gap, input string req);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_cs_n = 1'b0;
        if (is_wr) bus_wr_n = 1'b0; else bus_rd_n = 1'b0;
        #1;
        if (!is_wr) chk(req, bus_rdata, exp_rd(a));
        repeat (3) @(negedge clk);
        bus_cs_n = 1'b1; bus_rd_n = 1'b1; bus_wr_n = 1'b1; bus_addr = rel_a;
        commit(is_wr, a, d);
        repeat (gap) @(negedge clk);
        if (gap >= 5) begin
            #1;
            chk((rel_a > 5'd3) ? "R9 idle read" : "R8 idle read", bus_rdata, exp_rd(rel_a));
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d, input string req);
        access(1'b1, a, d, a ^ 5'h1F, 6, req);
    endtask

    task automatic rd(input logic [4:0] a, input string req);
        access(1'b0, a, 8'h00, a ^ 5'h1F, 6, req);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 reset state, R10 reads have no side effect
        rd(5'd0, "R1 ptr lo"); rd(5'd1, "R1 ptr hi"); rd(5'd2, "R1 step");
        rd(5'd0, "R10 ptr lo after reads");

        // R2, R3 register setup
        wr(5'd2, 8'hF1, "R3");
        rd(5'd2, "R3 step readback masks high nibble");
        wr(5'd0, 8'h00, "R2"); wr(5'd1, 8'hFD, "R2");
        rd(5'd0, "R2 ptr lo"); rd(5'd1, "R2 ptr hi keeps low bits");

        // R6, R5 data writes with unit step
        wr(5'd3, 8'h20, "R6"); wr(5'd3, 8'h61, "R6");
        wr(5'd3, 8'h7A, "R6"); wr(5'd3, 8'h33, "R6");
        rd(5'd0, "R5 ptr after four writes");

        // R7 back-to-back reads return successive bytes; R4 valid at strobe
        wr(5'd0, 8'h00, "R2");
        access(1'b0, 5'd3, 8'h00, 5'd28, 3, "R7 first read");
        access(1'b0, 5'd3, 8'h00, 5'd28, 3, "R7 second read");
        access(1'b0, 5'd3, 8'h00, 5'd28, 3, "R7 third read");
        rd(5'd3, "R4 fourth byte");
        rd(5'd0, "R5 ptr after reads");

        // R5 wrap with step 4 and R3 code 3
        wr(5'd2, 8'h03, "R3"); wr(5'd1, 8'h03, "R2"); wr(5'd0, 8'hFC, "R2");
        wr(5'd3, 8'hAA, "R6 top byte");
        rd(5'd0, "R5 wrap lo"); rd(5'd1, "R5 wrap hi");
        wr(5'd0, 8'hFC, "R2"); wr(5'd1, 8'h03, "R2");
        rd(5'd3, "R4 read at top");

        // R3 code 9 gives 256
        wr(5'd2, 8'h09, "R3"); wr(5'd1, 8'h01, "R2"); wr(5'd0, 8'h01, "R2");
        rd(5'd3, "R4 step 256");
        rd(5'd1, "R5 hi after 256 step"); rd(5'd0, "R5 lo after 256 step");

        // R11 zero step, and R3 code 12 also zero
        wr(5'd2, 8'h00, "R11"); wr(5'd1, 8'h01, "R2"); wr(5'd0, 8'h01, "R2");
        access(1'b0, 5'd3, 8'h00, 5'd28, 3, "R11 first");
        access(1'b0, 5'd3, 8'h00, 5'd28, 3, "R11 second");
        rd(5'd0, "R11 ptr unchanged");
        wr(5'd2, 8'h0C, "R3");
        rd(5'd3, "R3 code 12 read"); rd(5'd0, "R3 code 12 no advance");

        // R9 unmapped offsets are inert
        wr(5'd2, 8'h01, "R3");
        wr(5'd5, 8'h3C, "R9"); wr(5'd31, 8'hFF, "R9"); wr(5'd4, 8'h02, "R9");
        rd(5'd0, "R9 ptr lo"); rd(5'd2, "R9 step"); rd(5'd20, "R9 read zero");
        rd(5'd3, "R9 memory kept");

        // R8 address moves onto another offset exactly at release
        wr(5'd0, 8'h02, "R2");
        access(1'b1, 5'd0, 8'h01, 5'd3, 6, "R8 ptr write released onto data port");
        rd(5'd0, "R8 ptr lo from held offset");
        rd(5'd3, "R8 memory not written");
        access(1'b0, 5'd3, 8'h00, 5'd0, 6, "R8 data read released onto ptr lo");
        rd(5'd0, "R8 ptr advanced once");
        access(1'b1, 5'd3, 8'h5E, 5'd2, 6, "R8 data write released onto step");
        wr(5'd0, 8'h02, "R2");
        rd(5'd3, "R8 written byte at held pointer");
        rd(5'd2, "R8 step untouched");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule